// File: doc/BRIEF.md
# Write-Through Snooping Private Cache Controller

This block is the private cache controller that sits between one processor and a shared bus in a small multiprocessor. It holds a direct-mapped array of one-word lines. Each line has a tag and a valid flag. The processor issues single-word loads and stores through a ready/valid request and gets a one-cycle response pulse back. Every store is written through to shared memory with a bus write. A store that hits also refreshes the local copy. A load that misses fetches the word over the bus and installs it before answering. A store that misses does not allocate a line.

Coherence is kept by watching the write traffic of the other bus masters. A write from a peer that matches a valid local line is handled in one of two ways, chosen at run time by a mode pin. In update mode the broadcast value replaces the local word. In invalidate mode the line is dropped, so the next local load fetches the word again. The controller ignores bus reads, writes that miss its tags, and its own writes echoed back with its own master ID. When a peer write hits the line that a pending lookup or fill is working on, the snoop is applied first and the local step waits one cycle.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset, cpu_req_ready is 1, and cpu_rsp_valid and bus_req_valid are 0. Every line is invalid, so the first load of any address misses.
- R2: A load miss raises bus_req_valid with bus_req_we=0 and bus_req_addr equal to the load address. That request is held until bus_gnt. The word arriving with mem_rsp_valid is installed and returned on cpu_rsp_rdata.
- R3: A load hit makes no bus request and raises cpu_rsp_valid for one cycle, on the second clock edge after the request is accepted.
- R4: Every store raises one bus write with bus_req_we=1, carrying the store address and data. On a hit, the local word is also replaced, so a later load hits with the new value.
- R5: A store miss leaves the cache unchanged (no write-allocate), so a later load of that address misses.
- R6: With snp_mode=1, a peer write (snp_valid=1, snp_we=1, snp_id different from the own ID) that hits a valid line replaces that line's word with snp_data.
- R7: With snp_mode=0, a peer write that hits a valid line clears its valid flag, so the next load misses.
- R8: A peer write whose tag differs from the valid line at its index changes nothing, in either mode.
- R9: A snooped transaction with snp_we=0 changes nothing.
- R10: A snooped write carrying the controller's own ID changes nothing.
- R11: A peer write that hits during the lookup of a pending local access is applied first. The lookup is repeated one cycle later, so the load returns the snooped value.
- R12: Only one processor request is outstanding at a time: cpu_req_ready stays 0 from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data, valid with cpu_rsp_valid on loads |
| bus_req_valid | output | 1 | Bus transaction request, held until granted |
| bus_req_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_req_addr | output | ADDR_W | Bus transaction address |
| bus_req_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Bus grant, completes the request phase |
| mem_rsp_valid | input | 1 | Read data from memory for this controller |
| mem_rsp_data | input | DATA_W | Memory read word |
| snp_valid | input | 1 | Observed bus transaction present |
| snp_we | input | 1 | Observed transaction is a write |
| snp_id | input | ID_W | Master ID of the observed transaction |
| snp_addr | input | ADDR_W | Observed address |
| snp_data | input | DATA_W | Observed write data |
| snp_mode | input | 1 | 1 = update matching copy, 0 = invalidate it |

## Verification
A snoop presented before a clock edge takes effect at that edge. A load hit answers on the second edge after acceptance. A stalled lookup answers on the third. A bus request appears one edge after the lookup and ends at the edge where it is granted. A memory word answers the processor three edges after it is taken. The bench drives and samples only on falling edges, so each check reads the outputs half a cycle after the edge that produced them. Each check counts the falling edges since the request to confirm the exact hit latency, and the bus reads and writes it observes to tell hits from misses. The one-cycle stall caused by a snoop is checked edge by edge.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RESP,
    ST_BUSRD,
    ST_MEMWT,
    ST_FILL,
    ST_BUSWR,
    ST_WACK
  } wtsc_state_e;
endpackage

// File: rtl/wtsc_tag_store.sv
module wtsc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 12,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_vld,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_vld,
  output logic [TAG_W-1:0] b_tag,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [LINES-1:0] vld_vec
);
  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (clr_en) vld_q[clr_idx] <= 1'b0;
      if (set_en) vld_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tags[set_idx] <= set_tag;
  end

  assign a_vld   = vld_q[a_idx];
  assign a_tag   = tags[a_idx];
  assign b_vld   = vld_q[b_idx];
  assign b_tag   = tags[b_idx];
  assign vld_vec = vld_q;
endmodule

// File: rtl/wtsc_data_store.sv
module wtsc_data_store #(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wtsc_ctrl.sv
module wtsc_ctrl
  import wtsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  input  logic              lk_hit,
  input  logic              snp_hit,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              bus_req_valid,
  output logic              bus_req_we,
  input  logic              bus_gnt,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              tag_set
);
  wtsc_state_e       st_q, st_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      fill_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && cpu_req_valid) begin
        we_q    <= cpu_req_we;
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
      end
      if (st_q == ST_MEMWT && mem_rsp_valid) fill_q <= mem_rsp_data;
    end
  end

  always_comb begin
    st_d    = st_q;
    wr_en   = 1'b0;
    wr_data = wdata_q;
    tag_set = 1'b0;
    case (st_q)
      ST_IDLE:  if (cpu_req_valid) st_d = ST_LOOK;
      ST_LOOK: begin
        if (!snp_hit) begin
          if (we_q) begin
            wr_en = lk_hit;
            st_d  = ST_BUSWR;
          end else begin
            st_d = lk_hit ? ST_RESP : ST_BUSRD;
          end
        end
      end
      ST_RESP:  st_d = ST_IDLE;
      ST_BUSRD: if (bus_gnt) st_d = ST_MEMWT;
      ST_MEMWT: if (mem_rsp_valid) st_d = ST_FILL;
      ST_FILL: begin
        if (!snp_hit) begin
          wr_en   = 1'b1;
          wr_data = fill_q;
          tag_set = 1'b1;
          st_d    = ST_LOOK;
        end
      end
      ST_BUSWR: if (bus_gnt) st_d = ST_WACK;
      ST_WACK:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign cpu_req_ready = (st_q == ST_IDLE);
  assign cpu_rsp_valid = (st_q == ST_RESP) || (st_q == ST_WACK);
  assign bus_req_valid = (st_q == ST_BUSRD) || (st_q == ST_BUSWR);
  assign bus_req_we    = (st_q == ST_BUSWR);
  assign req_addr      = addr_q;
  assign req_wdata     = wdata_q;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  output logic              bus_req_we,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_gnt,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ID_W-1:0]   snp_id,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  input  logic              snp_mode
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              a_vld, b_vld, lk_hit;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic              snp_fire, snp_hit, snp_upd, snp_inv;
  logic              ctl_wr_en, tag_set;
  logic [DATA_W-1:0] ctl_wr_data;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [LINES-1:0]  line_valid;

  // Peer write decode: only writes from other masters that hit a valid line act.
  assign snp_fire = snp_valid && snp_we && (snp_id != OWN_ID);
  assign snp_hit  = snp_fire && b_vld && (b_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign snp_upd  = snp_hit && snp_mode;
  assign snp_inv  = snp_hit && !snp_mode;
  assign lk_hit   = a_vld && (a_tag == req_addr[ADDR_W-1:IDX_W]);

  // Single RAM write port; the controller never writes while a snoop hits.
  assign ram_we    = snp_upd || ctl_wr_en;
  assign ram_waddr = snp_upd ? snp_addr[IDX_W-1:0] : req_addr[IDX_W-1:0];
  assign ram_wdata = snp_upd ? snp_data : ctl_wr_data;

  wtsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_we    (cpu_req_we),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .lk_hit        (lk_hit),
    .snp_hit       (snp_hit),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .bus_req_valid (bus_req_valid),
    .bus_req_we    (bus_req_we),
    .bus_gnt       (bus_gnt),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .wr_en         (ctl_wr_en),
    .wr_data       (ctl_wr_data),
    .tag_set       (tag_set)
  );

  wtsc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .a_idx   (req_addr[IDX_W-1:0]),
    .a_vld   (a_vld),
    .a_tag   (a_tag),
    .b_idx   (snp_addr[IDX_W-1:0]),
    .b_vld   (b_vld),
    .b_tag   (b_tag),
    .set_en  (tag_set),
    .set_idx (req_addr[IDX_W-1:0]),
    .set_tag (req_addr[ADDR_W-1:IDX_W]),
    .clr_en  (snp_inv),
    .clr_idx (snp_addr[IDX_W-1:0]),
    .vld_vec (line_valid)
  );

  wtsc_data_store #(.LINES(LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (req_addr[IDX_W-1:0]),
    .rdata (cpu_rsp_rdata)
  );

  assign bus_req_addr  = req_addr;
  assign bus_req_wdata = req_wdata;
endmodule

// File: rtl/wtsc_checker.sv
module wtsc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              bus_req_valid,
  input logic              bus_req_we,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic [DATA_W-1:0] bus_req_wdata,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic              snp_we,
  input logic [ID_W-1:0]   snp_id,
  input logic [LINES-1:0]  line_valid,
  input logic              tag_set
);
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

  // R12: a request is accepted only when nothing is outstanding
  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  // R1: no bus activity while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    cpu_req_ready |-> !bus_req_valid);

  // R2: an ungranted bus request holds its kind and address
  p_bus_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_gnt) |=>
      (bus_req_valid && $stable(bus_req_we) && $stable(bus_req_addr)));

  // R4: an ungranted bus write holds its data
  p_wdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_we && !bus_gnt) |=> $stable(bus_req_wdata));

  // R3: the response is a single-cycle pulse
  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R9: snooped reads leave the valid flags alone
  p_snoop_read_r9: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !snp_we && !tag_set) |=> $stable(line_valid));

  // R10: own writes seen on the bus leave the valid flags alone
  p_own_write_r10: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_id == OWN_ID && !tag_set) |=> $stable(line_valid));
endmodule

bind wt_snoop_cache wtsc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .bus_req_valid (bus_req_valid),
  .bus_req_we    (bus_req_we),
  .bus_req_addr  (bus_req_addr),
  .bus_req_wdata (bus_req_wdata),
  .bus_gnt       (bus_gnt),
  .snp_valid     (snp_valid),
  .snp_we        (snp_we),
  .snp_id        (snp_id),
  .line_valid    (line_valid),
  .tag_set       (tag_set)
);

// File: tb/tb_wt_snoop_cache.sv
module tb_wt_snoop_cache;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam logic [IW-1:0] MY   = 2'd1;
  localparam logic [IW-1:0] PEER = 2'd2;

  logic          clk = 1'b0;
  logic          rst;
  logic          cpu_req_valid, cpu_req_ready, cpu_req_we;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          bus_req_valid, bus_req_we;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_wdata;
  logic          bus_gnt;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          snp_valid, snp_we, snp_mode;
  logic [IW-1:0] snp_id;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] bmem [256];

  always #10 clk = ~clk;

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16), .ID_W(IW), .MY_ID(1)) dut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_we(bus_req_we),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata), .bus_gnt(bus_gnt),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_id(snp_id),
    .snp_addr(snp_addr), .snp_data(snp_data), .snp_mode(snp_mode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One processor access; services the bus and counts what it sees.
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int nrd, output int nwr,
                        output int lat, output bit busy_ready,
                        output logic [AW-1:0] wa, output logic [DW-1:0] wd);
    logic          pend;
    logic [AW-1:0] ra;
    nrd = 0; nwr = 0; lat = 0; busy_ready = 0; rd = '0; wa = '0; wd = '0;
    pend = 1'b0; ra = '0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      cpu_req_valid = 1'b0;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = bmem[ra[7:0]];
        pend = 1'b0;
      end
      if (cpu_rsp_valid) begin
        rd  = cpu_rsp_rdata;
        lat = i;
        break;
      end
      if (cpu_req_ready) busy_ready = 1'b1;
      if (bus_req_valid) begin
        if (bus_req_we) begin
          nwr++;
          wa = bus_req_addr; wd = bus_req_wdata;
          bmem[bus_req_addr[7:0]] = bus_req_wdata;
        end else begin
          nrd++;
          ra = bus_req_addr;
          pend = 1'b1;
        end
      end
    end
  endtask

  task automatic snoop(input logic [IW-1:0] id, input logic we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_we = we; snp_id = id; snp_addr = a; snp_data = d;
    if (we && id != MY) bmem[a[7:0]] = d;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a,
                          input int exp_nrd, input logic [DW-1:0] exp_d);
    logic [DW-1:0] rd; logic [AW-1:0] wa; logic [DW-1:0] wd;
    int nrd, nwr, lat; bit br;
    access(1'b0, a, '0, rd, nrd, nwr, lat, br, wa, wd);
    chk(nrd == exp_nrd, req, "bus reads", nrd, exp_nrd);
    chk(rd === exp_d, req, "load data", rd, exp_d);
  endtask

  task automatic t_reset;
    chk(cpu_req_ready === 1'b1, "R1", "ready after reset", cpu_req_ready, 1);
    chk(cpu_rsp_valid === 1'b0, "R1", "rsp after reset", cpu_rsp_valid, 0);
    chk(bus_req_valid === 1'b0, "R1", "bus after reset", bus_req_valid, 0);
  endtask

  task automatic t_read_miss;
    logic [DW-1:0] rd; logic [AW-1:0] wa; logic [DW-1:0] wd;
    int nrd, nwr, lat; bit br;
    access(1'b0, 16'h0005, '0, rd, nrd, nwr, lat, br, wa, wd);
    chk(nrd == 1, "R1", "first load misses", nrd, 1);
    chk(rd === bmem[5], "R2", "fill data", rd, bmem[5]);
    chk(br == 1'b0, "R12", "ready while busy", br, 0);
  endtask

  task automatic t_read_hit;
    logic [DW-1:0] rd; logic [AW-1:0] wa; logic [DW-1:0] wd;
    int nrd, nwr, lat; bit br;
    access(1'b0, 16'h0005, '0, rd, nrd, nwr, lat, br, wa, wd);
    chk(nrd == 0, "R3", "hit bus reads", nrd, 0);
    chk(lat == 2, "R3", "hit latency", lat, 2);
    chk(rd === 32'hC0DE_0005, "R3", "hit data", rd, 32'hC0DE_0005);
  endtask

  task automatic t_write_hit;
    logic [DW-1:0] rd; logic [AW-1:0] wa; logic [DW-1:0] wd;
    int nrd, nwr, lat; bit br;
    access(1'b1, 16'h0005, 32'h1111_1111, rd, nrd, nwr, lat, br, wa, wd);
    chk(nwr == 1, "R4", "bus writes", nwr, 1);
    chk(wa === 16'h0005, "R4", "bus write addr", wa, 16'h0005);
    chk(wd === 32'h1111_1111, "R4", "bus write data", wd, 32'h1111_1111);
    rd_check("R4", 16'h0005, 0, 32'h1111_1111);
  endtask

  task automatic t_write_miss;
    logic [DW-1:0] rd; logic [AW-1:0] wa; logic [DW-1:0] wd;
    int nrd, nwr, lat; bit br;
    access(1'b1, 16'h0023, 32'h2323_2323, rd, nrd, nwr, lat, br, wa, wd);
    chk(nwr == 1, "R5", "miss store bus writes", nwr, 1);
    rd_check("R5", 16'h0023, 1, 32'h2323_2323);
  endtask

  task automatic t_snoop_update;
    snp_mode = 1'b1;
    snoop(PEER, 1'b1, 16'h0005, 32'h2222_2222);
    rd_check("R6", 16'h0005, 0, 32'h2222_2222);
  endtask

  task automatic t_snoop_miss;
    snp_mode = 1'b1;
    snoop(PEER, 1'b1, 16'h0015, 32'h4444_4444);
    rd_check("R8", 16'h0005, 0, 32'h2222_2222);
    snp_mode = 1'b0;
    snoop(PEER, 1'b1, 16'h0015, 32'h4545_4545);
    rd_check("R8", 16'h0005, 0, 32'h2222_2222);
  endtask

  task automatic t_snoop_read;
    snp_mode = 1'b0;
    snoop(PEER, 1'b0, 16'h0005, 32'h9999_9999);
    rd_check("R9", 16'h0005, 0, 32'h2222_2222);
  endtask

  task automatic t_own_id;
    snp_mode = 1'b0;
    snoop(MY, 1'b1, 16'h0005, 32'h5555_5555);
    rd_check("R10", 16'h0005, 0, 32'h2222_2222);
    snp_mode = 1'b1;
    snoop(MY, 1'b1, 16'h0005, 32'h5656_5656);
    rd_check("R10", 16'h0005, 0, 32'h2222_2222);
  endtask

  task automatic t_same_cycle;
    snp_mode = 1'b1;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = 16'h0005;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    snp_valid = 1'b1; snp_we = 1'b1; snp_id = PEER;
    snp_addr = 16'h0005; snp_data = 32'h6666_6666;
    bmem[5] = 32'h6666_6666;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(cpu_rsp_valid === 1'b0, "R11", "lookup stalled", cpu_rsp_valid, 0);
    @(negedge clk);
    chk(cpu_rsp_valid === 1'b1, "R11", "rsp after stall", cpu_rsp_valid, 1);
    chk(cpu_rsp_rdata === 32'h6666_6666, "R11", "snoop first data",
        cpu_rsp_rdata, 32'h6666_6666);
    chk(bus_req_valid === 1'b0, "R11", "no bus read", bus_req_valid, 0);
  endtask

  task automatic t_snoop_inv;
    snp_mode = 1'b0;
    snoop(PEER, 1'b1, 16'h0005, 32'h3333_3333);
    rd_check("R7", 16'h0005, 1, 32'h3333_3333);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 | i;
    rst = 1'b1;
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    bus_gnt = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    snp_valid = 1'b0; snp_we = 1'b0; snp_id = '0; snp_addr = '0; snp_data = '0;
    snp_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_snoop_update();
    t_snoop_miss();
    t_snoop_read();
    t_own_id();
    t_same_cycle();
    t_snoop_inv();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule